// File: doc/BRIEF.md
# DMA-Coherent Directory Access Path

This block sits beside the directory of a home node and serves DMA read and DMA write requests without breaking cache coherence. For each accepted request it aligns the byte address to a line, looks up the stable directory state, the sharer vector, the owner and the stored line through a lookup port, and decides what to do. Depending on that state it answers from the stored line, fetches the line from memory, or forwards the request to the owning node. It merges partial write data into the line, writes it back to memory, invalidates the sharers, and returns an acknowledgement. The acknowledgement carries the number of invalidation replies the DMA engine must collect.

Only one DMA transaction is open at a time. The transient wait states live in the block, while the stable state, sharers, owner and data stay in the external directory. The block updates that directory through a write port, and the write takes effect at the same clock edge as the event that causes it. When the line is owned, a DMA write is parked in a one-entry tracking buffer. The owner's copy is then recalled, the saved bytes are laid over the returned data, and the result is written back. While any transaction is open the request port deasserts ready, so a new request, including a second write, is retried by the sender.

Top module: `dmadir_home`

## Requirements
- R1: The line index given to the directory lookup and to memory is the DMA address with its low log2(LINE_BYTES) bits dropped. The byte offset is those low bits.
- R2: A DMA read that finds the line in I (state code 0) issues a memory read (mem_write=0) one cycle after acceptance and drops ready. When memory data returns, that data appears on the read-data output one cycle later, addressed to the original requester, and ready rises again.
- R3: A DMA read that finds the line in S (code 1) returns the stored line one cycle after acceptance. It addresses the read data to the requester, makes no memory access and leaves the directory unchanged.
- R4: A DMA write that finds the line in I or S replaces bytes offset to offset+len-1 of the stored line with the same byte lanes of the write bus. Byte b occupies bits 8b+7:8b. All other bytes are kept, and the directory is updated at the acceptance edge.
- R5: A DMA write in I or S leads, one cycle after acceptance, to a memory writeback of the merged line. It also sends an acknowledgement to the requester whose count equals the number of set sharer bits. Invalidations go to the sharers minus the requester, and inv_valid is raised only if that set is non-empty. The block then waits for an unblock with ready low.
- R6: While waiting for an unblock, a response of kind 1 (exclusive unblock) writes the directory to state I with no sharers and owner 0, and ready rises.
- R7: A DMA write that finds the line in O (code 2) or M (code 3) forwards a write to the owner with the directory-as-requester flag set. It invalidates the sharers minus the requester, makes no memory access, sends no acknowledgement and leaves the stored line unchanged.
- R8: After such a forward, a response of kind 2 (owner data) stores the returned line with the saved DMA bytes laid over it. It writes that line back to memory and acknowledges the original requester with the current sharer count. The block then waits for an unblock.
- R9: A DMA read in O or M forwards a read (fwd_write=0, directory flag clear) to the owner, carrying the requester id. A response of kind 3 (DMA done) frees the port, and the directory is left untouched.
- R10: While a transaction is open, ready is low, a presented request has no effect, and responses of a kind other than the awaited one are ignored.
- R11: A DMA write with length 0 or with offset+length above LINE_BYTES raises dma_err for one cycle. It produces no other output and no directory change, and the block stays ready.
- R12: After reset, ready is high and all output pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_valid | input | 1 | DMA request present |
| dma_ready | output | 1 | Request accepted when high together with dma_valid |
| dma_write | input | 1 | 1 = write, 0 = read |
| dma_addr | input | ADDR_W | Byte address |
| dma_len | input | LEN_W | Write length in bytes |
| dma_wdata | input | DATA_W | Write data in line byte lanes |
| dma_src | input | NODE_W | Requester id |
| dir_line | output | LINE_W | Directory lookup index |
| dir_state_in | input | 2 | Stable state of looked-up line |
| dir_sharers_in | input | NODES | Sharer vector |
| dir_owner_in | input | NODE_W | Owner id |
| dir_data_in | input | DATA_W | Stored line |
| dir_we | output | 1 | Directory update strobe |
| dir_state_out | output | 2 | New state |
| dir_sharers_out | output | NODES | New sharer vector |
| dir_owner_out | output | NODE_W | New owner |
| dir_data_out | output | DATA_W | New line |
| rsp_valid | input | 1 | Node response present |
| rsp_kind | input | 2 | 1 unblock, 2 owner data, 3 DMA done |
| rsp_data | input | DATA_W | Owner data |
| mem_valid | output | 1 | Memory request pulse |
| mem_write | output | 1 | 1 = writeback, 0 = fetch |
| mem_line | output | LINE_W | Memory line index |
| mem_wdata | output | DATA_W | Writeback data |
| mem_rvalid | input | 1 | Memory read data present |
| mem_rdata | input | DATA_W | Memory read data |
| fwd_valid | output | 1 | Forward to owner pulse |
| fwd_write | output | 1 | Forwarded request is a write |
| fwd_dir_req | output | 1 | Directory stands as requester |
| fwd_dest | output | NODE_W | Owner id |
| fwd_req_id | output | NODE_W | DMA requester id |
| inv_valid | output | 1 | Invalidation pulse |
| inv_mask | output | NODES | Nodes to invalidate |
| ack_valid | output | 1 | Write acknowledgement pulse |
| ack_dest | output | NODE_W | Acknowledged requester |
| ack_count | output | CNT_W | Invalidation replies to collect |
| rdata_valid | output | 1 | Read data pulse |
| rdata_dest | output | NODE_W | Read requester |
| rdata | output | DATA_W | Read line |
| dma_err | output | 1 | Malformed write pulse |

## Verification
The merge is tried with a full-line write, a single top byte, a mid-line span, an end-aligned span and an owner recall overlay. Together they separate an off-by-one at either end of the byte window from a wrong lane choice. The sharer patterns cover an empty vector, a set that holds the requester, a set without it and a full set. These tell the acknowledgement count, which counts every sharer, apart from the invalidation mask, which drops the requester. The length checks use a zero length, a span one byte past the line end and a length above the line size, and a legal end-aligned span sits beside them. The open-transaction cases present a request and a wrong response kind during a wait, and the check shows that neither disturbs the directory or the outputs.

// File: rtl/dmadir_pkg.sv
package dmadir_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_O = 2'd2, ST_M = 2'd3} dstate_e;
  typedef enum logic [1:0] {RK_NONE = 2'd0, RK_UNBLK_X = 2'd1, RK_OWN_DATA = 2'd2,
                            RK_DMA_DONE = 2'd3} rkind_e;
  typedef enum logic [2:0] {F_IDLE, F_XIM, F_XIU, F_OID, F_OD, F_MD} fsm_e;
endpackage

// File: rtl/dmadir_merge.sv
module dmadir_merge #(
  parameter int LINE_BYTES = 16,
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int LEN_W = OFF_W + 1,
  localparam int DATA_W = 8 * LINE_BYTES
) (
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W-1:0] upd_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [DATA_W-1:0] line_o
);
  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
    logic take;
    assign take = (32'(b) >= 32'(off_i)) && (32'(b) < 32'(off_i) + 32'(len_i));
    assign line_o[b*8 +: 8] = take ? upd_i[b*8 +: 8] : base_i[b*8 +: 8];
  end
endmodule

// File: rtl/dmadir_trk.sv
module dmadir_trk #(
  parameter int LINE_BYTES = 16,
  parameter int LINE_W = 8,
  parameter int NODE_W = 2,
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int LEN_W = OFF_W + 1,
  localparam int DATA_W = 8 * LINE_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_ld,
  input  logic              pay_ld,
  input  logic              pay_clr,
  input  logic [LINE_W-1:0] line_i,
  input  logic [NODE_W-1:0] src_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [LINE_W-1:0] line_o,
  output logic [NODE_W-1:0] src_o,
  output logic [OFF_W-1:0]  off_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [DATA_W-1:0] data_o,
  output logic              pay_vld_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_o <= '0; src_o <= '0; off_o <= '0; len_o <= '0; data_o <= '0; pay_vld_o <= 1'b0;
    end else begin
      if (hdr_ld) begin
        line_o <= line_i;
        src_o  <= src_i;
      end
      if (pay_ld) begin
        off_o  <= off_i;
        len_o  <= len_i;
        data_o <= data_i;
      end
      if (pay_ld)       pay_vld_o <= 1'b1;
      else if (pay_clr) pay_vld_o <= 1'b0;
    end
  end

  // R8: a parked write payload stays put until the owner data consumes it
  p_trk_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_vld_o && !pay_ld) |=> $stable(data_o) && $stable(off_o) && $stable(len_o));
endmodule

// File: rtl/dmadir_home.sv
module dmadir_home
  import dmadir_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NODES = 4,
  parameter int LINE_BYTES = 16,
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int LEN_W = OFF_W + 1,
  localparam int NODE_W = $clog2(NODES),
  localparam int CNT_W = $clog2(NODES + 1),
  localparam int DATA_W = 8 * LINE_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_valid,
  output logic              dma_ready,
  input  logic              dma_write,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic [LEN_W-1:0]  dma_len,
  input  logic [DATA_W-1:0] dma_wdata,
  input  logic [NODE_W-1:0] dma_src,
  output logic [LINE_W-1:0] dir_line,
  input  logic [1:0]        dir_state_in,
  input  logic [NODES-1:0]  dir_sharers_in,
  input  logic [NODE_W-1:0] dir_owner_in,
  input  logic [DATA_W-1:0] dir_data_in,
  output logic              dir_we,
  output logic [1:0]        dir_state_out,
  output logic [NODES-1:0]  dir_sharers_out,
  output logic [NODE_W-1:0] dir_owner_out,
  output logic [DATA_W-1:0] dir_data_out,
  input  logic              rsp_valid,
  input  logic [1:0]        rsp_kind,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [LINE_W-1:0] mem_line,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              fwd_valid,
  output logic              fwd_write,
  output logic              fwd_dir_req,
  output logic [NODE_W-1:0] fwd_dest,
  output logic [NODE_W-1:0] fwd_req_id,
  output logic              inv_valid,
  output logic [NODES-1:0]  inv_mask,
  output logic              ack_valid,
  output logic [NODE_W-1:0] ack_dest,
  output logic [CNT_W-1:0]  ack_count,
  output logic              rdata_valid,
  output logic [NODE_W-1:0] rdata_dest,
  output logic [DATA_W-1:0] rdata,
  output logic              dma_err
);
  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  fsm_e fsm_q, fsm_d;
  logic              accept, len_bad;
  logic [LINE_W-1:0] req_line, trk_line;
  logic [OFF_W-1:0]  req_off, trk_off;
  logic [LEN_W-1:0]  trk_len;
  logic [NODE_W-1:0] trk_src;
  logic [DATA_W-1:0] trk_data, mrg_now, mrg_trk;
  logic              trk_pay_vld, pay_ld, pay_clr;
  logic [NODES-1:0]  others;
  logic [CNT_W-1:0]  shr_cnt;
  dstate_e           cur_st;
  rkind_e            kind;

  assign req_line  = dma_addr[ADDR_W-1:OFF_W];
  assign req_off   = dma_addr[OFF_W-1:0];
  assign dma_ready = (fsm_q == F_IDLE);
  assign accept    = dma_valid && dma_ready;
  assign len_bad   = (dma_len == '0) || (32'(dma_len) + 32'(req_off) > LINE_BYTES);
  assign dir_line  = dma_ready ? req_line : trk_line;
  assign cur_st    = dstate_e'(dir_state_in);
  assign kind      = rkind_e'(rsp_kind);
  assign others    = dir_sharers_in & ~(NODES'(1) << dma_src);
  assign shr_cnt   = CNT_W'($countones(dir_sharers_in));

  dmadir_merge #(.LINE_BYTES(LINE_BYTES)) u_mrg_now (
    .base_i(dir_data_in), .upd_i(dma_wdata), .off_i(req_off), .len_i(dma_len), .line_o(mrg_now));
  dmadir_merge #(.LINE_BYTES(LINE_BYTES)) u_mrg_trk (
    .base_i(rsp_data), .upd_i(trk_data), .off_i(trk_off), .len_i(trk_len), .line_o(mrg_trk));

  dmadir_trk #(.LINE_BYTES(LINE_BYTES), .LINE_W(LINE_W), .NODE_W(NODE_W)) u_trk (
    .clk(clk), .rst_n(rst_n_s), .hdr_ld(accept), .pay_ld(pay_ld), .pay_clr(pay_clr),
    .line_i(req_line), .src_i(dma_src), .off_i(req_off), .len_i(dma_len), .data_i(dma_wdata),
    .line_o(trk_line), .src_o(trk_src), .off_o(trk_off), .len_o(trk_len), .data_o(trk_data),
    .pay_vld_o(trk_pay_vld));

  // next-state and next-output logic
  logic mem_v_d, mem_w_d, fwd_v_d, fwd_w_d, fwd_dr_d, inv_v_d, ack_v_d, rd_v_d, err_d;
  logic [LINE_W-1:0] mem_line_d;
  logic [DATA_W-1:0] mem_data_d, rd_data_d;
  logic [NODE_W-1:0] ack_dest_d, rd_dest_d;
  logic [CNT_W-1:0]  ack_cnt_d;

  always_comb begin
    fsm_d = fsm_q;
    dir_we = 1'b0; dir_state_out = dir_state_in; dir_sharers_out = dir_sharers_in;
    dir_owner_out = dir_owner_in; dir_data_out = dir_data_in;
    mem_v_d = 1'b0; mem_w_d = 1'b0; mem_line_d = dir_line; mem_data_d = dir_data_in;
    fwd_v_d = 1'b0; fwd_w_d = 1'b0; fwd_dr_d = 1'b0;
    inv_v_d = 1'b0; ack_v_d = 1'b0; ack_dest_d = dma_src; ack_cnt_d = shr_cnt;
    rd_v_d = 1'b0; rd_dest_d = dma_src; rd_data_d = dir_data_in;
    err_d = 1'b0; pay_ld = 1'b0; pay_clr = 1'b0;
    case (fsm_q)
      F_IDLE: if (accept) begin
        if (dma_write && len_bad) begin
          err_d = 1'b1;
        end else if (dma_write) begin
          inv_v_d = (others != '0);
          if (cur_st == ST_I || cur_st == ST_S) begin
            dir_we = 1'b1; dir_data_out = mrg_now;
            mem_v_d = 1'b1; mem_w_d = 1'b1; mem_data_d = mrg_now;
            ack_v_d = 1'b1;
            fsm_d = F_XIU;
          end else begin
            fwd_v_d = 1'b1; fwd_w_d = 1'b1; fwd_dr_d = 1'b1;
            pay_ld = 1'b1;
            fsm_d = F_OID;
          end
        end else begin
          case (cur_st)
            ST_I: begin mem_v_d = 1'b1; fsm_d = F_XIM; end
            ST_S: rd_v_d = 1'b1;
            ST_O: begin fwd_v_d = 1'b1; fsm_d = F_OD; end
            default: begin fwd_v_d = 1'b1; fsm_d = F_MD; end
          endcase
        end
      end
      F_XIM: if (mem_rvalid) begin
        rd_v_d = 1'b1; rd_data_d = mem_rdata; rd_dest_d = trk_src;
        fsm_d = F_IDLE;
      end
      F_XIU: if (rsp_valid && kind == RK_UNBLK_X) begin
        dir_we = 1'b1; dir_state_out = ST_I; dir_sharers_out = '0; dir_owner_out = '0;
        fsm_d = F_IDLE;
      end
      F_OID: if (rsp_valid && kind == RK_OWN_DATA) begin
        dir_we = 1'b1; dir_data_out = mrg_trk;
        mem_v_d = 1'b1; mem_w_d = 1'b1; mem_data_d = mrg_trk;
        ack_v_d = 1'b1; ack_dest_d = trk_src;
        pay_clr = 1'b1;
        fsm_d = F_XIU;
      end
      F_OD, F_MD: if (rsp_valid && kind == RK_DMA_DONE) fsm_d = F_IDLE;
      default: fsm_d = F_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      fsm_q <= F_IDLE;
      mem_valid <= 1'b0; mem_write <= 1'b0; mem_line <= '0; mem_wdata <= '0;
      fwd_valid <= 1'b0; fwd_write <= 1'b0; fwd_dir_req <= 1'b0; fwd_dest <= '0; fwd_req_id <= '0;
      inv_valid <= 1'b0; inv_mask <= '0;
      ack_valid <= 1'b0; ack_dest <= '0; ack_count <= '0;
      rdata_valid <= 1'b0; rdata_dest <= '0; rdata <= '0;
      dma_err <= 1'b0;
    end else begin
      fsm_q       <= fsm_d;
      mem_valid   <= mem_v_d;
      fwd_valid   <= fwd_v_d;
      inv_valid   <= inv_v_d;
      ack_valid   <= ack_v_d;
      rdata_valid <= rd_v_d;
      dma_err     <= err_d;
      if (mem_v_d) begin
        mem_write <= mem_w_d; mem_line <= mem_line_d; mem_wdata <= mem_data_d;
      end
      if (fwd_v_d) begin
        fwd_write <= fwd_w_d; fwd_dir_req <= fwd_dr_d; fwd_dest <= dir_owner_in; fwd_req_id <= dma_src;
      end
      if (inv_v_d) inv_mask <= others;
      if (ack_v_d) begin
        ack_dest <= ack_dest_d; ack_count <= ack_cnt_d;
      end
      if (rd_v_d) begin
        rdata_dest <= rd_dest_d; rdata <= rd_data_d;
      end
    end
  end

  // R11: a rejected write stands alone
  p_err_alone_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    dma_err |-> !(mem_valid || fwd_valid || inv_valid || ack_valid || rdata_valid));
  // R11: a malformed write never reaches the directory
  p_err_no_dirwr_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (accept && dma_write && len_bad) |-> !dir_we);
  // R9: after a forward the port is closed
  p_fwd_busy_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    fwd_valid |-> !dma_ready);
  // R2: a memory fetch leaves the block waiting
  p_fetch_busy_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_valid && !mem_write) |-> !dma_ready);
  // R6: a drop to I leaves no holder
  p_unblock_clean_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (dir_we && fsm_q == F_XIU) |-> (dir_sharers_out == '0 && dir_state_out == ST_I));
endmodule

// File: tb/dmadir_home_bench.sv
`timescale 1ns/1ps
module dmadir_home_bench;
  localparam int ADDR_W = 8, NODES = 4, LB = 16;
  localparam int LINES = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic dma_valid = 0, dma_write = 0;
  logic [7:0] dma_addr = 0;
  logic [4:0] dma_len = 0;
  logic [127:0] dma_wdata = 0;
  logic [1:0] dma_src = 0;
  logic rsp_valid = 0; logic [1:0] rsp_kind = 0; logic [127:0] rsp_data = 0;
  logic mem_rvalid = 0; logic [127:0] mem_rdata = 0;
  logic dma_ready, dir_we, mem_valid, mem_write, fwd_valid, fwd_write, fwd_dir_req;
  logic inv_valid, ack_valid, rdata_valid, dma_err;
  logic [3:0] dir_line, mem_line, dir_sharers_out, inv_mask;
  logic [1:0] dir_state_out, dir_owner_out, fwd_dest, fwd_req_id, ack_dest, rdata_dest;
  logic [2:0] ack_count;
  logic [127:0] dir_data_out, mem_wdata, rdata;

  logic [1:0]   m_st  [LINES];
  logic [3:0]   m_shr [LINES];
  logic [1:0]   m_own [LINES];
  logic [127:0] m_dat [LINES];

  always @(posedge clk) if (dir_we) begin
    m_st[dir_line] <= dir_state_out; m_shr[dir_line] <= dir_sharers_out;
    m_own[dir_line] <= dir_owner_out; m_dat[dir_line] <= dir_data_out;
  end

  dmadir_home #(.ADDR_W(ADDR_W), .NODES(NODES), .LINE_BYTES(LB)) u_dmadir_home (
    .clk(clk), .rst_n(rst_n), .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_write(dma_write),
    .dma_addr(dma_addr), .dma_len(dma_len), .dma_wdata(dma_wdata), .dma_src(dma_src),
    .dir_line(dir_line), .dir_state_in(m_st[dir_line]), .dir_sharers_in(m_shr[dir_line]),
    .dir_owner_in(m_own[dir_line]), .dir_data_in(m_dat[dir_line]), .dir_we(dir_we),
    .dir_state_out(dir_state_out), .dir_sharers_out(dir_sharers_out), .dir_owner_out(dir_owner_out),
    .dir_data_out(dir_data_out), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_data(rsp_data),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_line(mem_line), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .fwd_valid(fwd_valid), .fwd_write(fwd_write),
    .fwd_dir_req(fwd_dir_req), .fwd_dest(fwd_dest), .fwd_req_id(fwd_req_id), .inv_valid(inv_valid),
    .inv_mask(inv_mask), .ack_valid(ack_valid), .ack_dest(ack_dest), .ack_count(ack_count),
    .rdata_valid(rdata_valid), .rdata_dest(rdata_dest), .rdata(rdata), .dma_err(dma_err));

  int checks = 0, fails = 0;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] base_line(int ln);
    logic [127:0] r;
    for (int b = 0; b < LB; b++) r[b*8 +: 8] = 8'(ln * 16 + b);
    return r;
  endfunction
  function automatic logic [127:0] wpat(int k);
    logic [127:0] r;
    for (int b = 0; b < LB; b++) r[b*8 +: 8] = 8'hC0 ^ 8'(b) ^ 8'(k * 8);
    return r;
  endfunction
  function automatic logic [127:0] exp_merge(logic [127:0] bl, logic [127:0] up, int off, int len);
    logic [127:0] r = bl;
    for (int b = 0; b < LB; b++) if (b >= off && b < off + len) r[b*8 +: 8] = up[b*8 +: 8];
    return r;
  endfunction

  task automatic set_line(int ln, logic [1:0] st, logic [3:0] shr, logic [1:0] own);
    m_st[ln] = st; m_shr[ln] = shr; m_own[ln] = own; m_dat[ln] = base_line(ln);
  endtask
  task automatic send_dma(logic wr, int ln, int off, int len, logic [127:0] wd, logic [1:0] src);
    @(negedge clk);
    dma_valid = 1; dma_write = wr; dma_addr = 8'(ln * 16 + off); dma_len = 5'(len);
    dma_wdata = wd; dma_src = src;
    @(posedge clk); #1;
    dma_valid = 0;
  endtask
  task automatic send_rsp(logic [1:0] k, logic [127:0] d);
    @(negedge clk); rsp_valid = 1; rsp_kind = k; rsp_data = d;
    @(posedge clk); #1; rsp_valid = 0;
  endtask

  // {write, state, sharers, offset, length, source}
  localparam logic [17:0] VEC [8] = '{
    {1'b1, 2'd0, 4'b0000, 4'd0,  5'd16, 2'd0},
    {1'b1, 2'd1, 4'b1011, 4'd3,  5'd5,  2'd1},
    {1'b1, 2'd1, 4'b0010, 4'd15, 5'd1,  2'd1},
    {1'b1, 2'd0, 4'b0000, 4'd8,  5'd9,  2'd0},
    {1'b1, 2'd1, 4'b0100, 4'd0,  5'd0,  2'd2},
    {1'b0, 2'd1, 4'b0110, 4'd7,  5'd4,  2'd3},
    {1'b1, 2'd1, 4'b1111, 4'd12, 5'd4,  2'd2},
    {1'b1, 2'd0, 4'b0000, 4'd1,  5'd20, 2'd1}};

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int l = 0; l < LINES; l++) set_line(l, 2'd0, 4'b0, 2'd0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk); #1;
    // R12 reset state
    chk("R12 ready", dma_ready, 1);
    chk("R12 pulses", {mem_valid, fwd_valid, inv_valid, ack_valid, rdata_valid, dma_err}, 0);

    // table walk: writes and reads resolved at acceptance
    for (int i = 0; i < 8; i++) begin
      logic wr; logic [1:0] st, src; logic [3:0] shr; int off, len, ln; bit bad;
      logic [127:0] wd, em; logic [3:0] others;
      wr = VEC[i][17]; st = VEC[i][16:15]; shr = VEC[i][14:11];
      off = int'(VEC[i][10:7]); len = int'(VEC[i][6:2]); src = VEC[i][1:0];
      ln = i + 1; wd = wpat(i);
      bad = wr && (len == 0 || off + len > LB);
      set_line(ln, st, shr, 2'd0);
      send_dma(wr, ln, off, len, wd, src);
      if (bad) begin
        chk("R11 err pulse", dma_err, 1);
        chk("R11 no side effect", {mem_valid, ack_valid, inv_valid, fwd_valid}, 0);
        chk("R11 line unchanged", m_dat[ln], base_line(ln));
        chk("R11 still ready", dma_ready, 1);
      end else if (!wr) begin
        chk("R3 read data", rdata, base_line(ln));
        chk("R3 read valid/dest", {rdata_valid, rdata_dest}, {1'b1, src});
        chk("R3 no memory", mem_valid, 0);
        chk("R3 state kept", m_st[ln], st);
      end else begin
        em = exp_merge(base_line(ln), wd, off, len);
        others = shr & ~(4'b1 << src);
        chk("R4 merged line", m_dat[ln], em);
        chk("R5 writeback", {mem_valid, mem_write, mem_wdata}, {2'b11, em});
        chk("R1 line index", mem_line, 4'(ln));
        chk("R5 ack", {ack_valid, ack_dest, ack_count}, {1'b1, src, 3'($countones(shr))});
        chk("R5 inv valid", inv_valid, (others != 0));
        if (others != 0) chk("R5 inv mask", inv_mask, others);
        chk("R5 busy", dma_ready, 0);
        send_rsp(2'd1, 0);
        chk("R6 state I", {m_st[ln], m_shr[ln], m_own[ln]}, 0);
        chk("R6 ready back", dma_ready, 1);
      end
    end

    // R2 read in I, with R10 held request and wrong response kind
    set_line(10, 2'd0, 4'b0, 2'd0);
    set_line(9, 2'd0, 4'b0, 2'd0);
    send_dma(0, 10, 5, 1, 0, 2'd3);
    chk("R2 fetch", {mem_valid, mem_write, mem_line}, {2'b10, 4'd10});
    chk("R2 busy", dma_ready, 0);
    @(negedge clk);
    dma_valid = 1; dma_write = 1; dma_addr = 8'h90; dma_len = 5'd4; dma_wdata = wpat(9); dma_src = 0;
    rsp_valid = 1; rsp_kind = 2'd1;
    @(posedge clk); #1;
    dma_valid = 0; rsp_valid = 0;
    chk("R10 held off", {dma_ready, ack_valid, mem_valid, dir_we}, 0);
    chk("R10 held line untouched", m_dat[9], base_line(9));
    chk("R10 wrong kind ignored", m_st[10], 2'd0);
    @(negedge clk); mem_rvalid = 1; mem_rdata = wpat(5);
    @(posedge clk); #1; mem_rvalid = 0;
    chk("R2 read data", {rdata_valid, rdata_dest, rdata}, {1'b1, 2'd3, wpat(5)});
    chk("R2 ready back", dma_ready, 1);

    // R7 / R8 write to owned line
    set_line(12, 2'd2, 4'b0101, 2'd3);
    send_dma(1, 12, 4, 6, wpat(2), 2'd1);
    chk("R7 forward", {fwd_valid, fwd_write, fwd_dir_req, fwd_dest}, {3'b111, 2'd3});
    chk("R7 inv", {inv_valid, inv_mask}, {1'b1, 4'b0101});
    chk("R7 no mem/ack", {mem_valid, ack_valid}, 0);
    chk("R7 line unchanged", m_dat[12], base_line(12));
    send_rsp(2'd2, wpat(7));
    chk("R8 overlay", m_dat[12], exp_merge(wpat(7), wpat(2), 4, 6));
    chk("R8 writeback", {mem_valid, mem_write, mem_wdata}, {2'b11, exp_merge(wpat(7), wpat(2), 4, 6)});
    chk("R8 ack", {ack_valid, ack_dest, ack_count}, {1'b1, 2'd1, 3'd2});
    chk("R8 waits unblock", dma_ready, 0);
    send_rsp(2'd1, 0);
    chk("R6 after recall", {m_st[12], m_shr[12], m_own[12], dma_ready}, {8'h00, 1'b1});

    // R9 read in O and M
    for (int k = 0; k < 2; k++) begin
      int ln = 13 + k;
      set_line(ln, (k == 0) ? 2'd2 : 2'd3, (k == 0) ? 4'b1000 : 4'b0000, 2'd1);
      send_dma(0, ln, 0, 1, 0, 2'd0);
      chk("R9 forward read", {fwd_valid, fwd_write, fwd_dir_req, fwd_dest, fwd_req_id},
          {3'b100, 2'd1, 2'd0});
      send_rsp(2'd2, wpat(1));
      chk("R9 wrong kind ignored", dma_ready, 0);
      send_rsp(2'd3, 0);
      chk("R9 done", dma_ready, 1);
      chk("R9 dir untouched", {m_st[ln], m_dat[ln]}, {(k == 0) ? 2'd2 : 2'd3, base_line(ln)});
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule